// File: doc/BRIEF.md
# Pipelined Column-Counting Multiplier

This block multiplies two unsigned operands of `OP_W` bits each and returns their full `2*OP_W`-bit product. It accepts a new operand pair on every clock cycle. The first stage registers every AND of an `op_x` bit with an `op_y` bit. The bit `op_x[i] & op_y[j]` carries weight 2^(i+j), so it is placed in column i+j of a bit matrix. Each reduction level then counts the ones in every column. The binary count of column c puts its bit j into column c+j of the next, shorter matrix. The levels repeat until no column holds more than two bits. A last stage adds those two rows into the product.

The number of counter levels grows with the logarithm of `OP_W`. The parameter `LVL_PER_REG` sets how many counter levels share one pipeline stage. A value of 1 registers every level, which gives the shortest cycle. Larger values merge levels, which saves latency cycles and makes each cycle longer. A valid flag travels with each operand pair, so a result comes out marked valid exactly one latency after its inputs.

Top module: `colcount_mult`

## Requirements
- R1: For every pair accepted with `op_vld` high, `res_prod` equals the unsigned product `op_x * op_y` in full `2*OP_W`-bit width.
- R2: One pair is accepted on every cycle. A run of N consecutive cycles with `op_vld` high produces a run of N consecutive valid results, each correct.
- R3: The latency is 2 + ceil(L / `LVL_PER_REG`) cycles. L is the number of counter levels. It is found by starting with a height h = `OP_W` and, while h > 2, replacing h with the number of bits needed to write h. For example, `OP_W`=4 gives L=2 and `OP_W`=8 gives L=3.
- R4: `res_vld` equals `op_vld` delayed by the latency of R3. A cycle with `op_vld` low produces no valid result, whatever the operands are.
- R5: When either operand is zero, the valid product is zero.
- R6: When both operands are all ones, the product is (2^`OP_W`-1)^2. No valid product ever exceeds that value.
- R7: When one operand has exactly one bit set, at position k, the product is the other operand shifted left by k.
- R8: While `rst_n` is low, `res_vld` is low. No valid result appears after reset until a valid pair has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_vld | input | 1 | Marks `op_x`/`op_y` as a pair to multiply this cycle |
| op_x | input | OP_W | Unsigned multiplicand |
| op_y | input | OP_W | Unsigned multiplier |
| res_vld | output | 1 | Marks `res_prod` as a product |
| res_prod | output | 2*OP_W | Unsigned product |

## Verification
Three instances run side by side: 4-bit operands with every level registered, 4-bit operands with two levels per stage, and 8-bit operands with three levels per stage. This compares the latencies that the register spacing produces. All 256 pairs of 4-bit operands are applied back to back, which covers every column height and carry path of the small configuration. A second phase applies zero, all-ones, single-bit and mixed-pattern operands in a valid/valid/idle rhythm. Any dependence of one product on its neighbours would show up there. Idle cycles carry junk operands, and a single isolated pair measures the latency directly.

// File: rtl/ccm_pkg.sv
`timescale 1ns/1ps
package ccm_pkg;

    // number of bits needed to write the value v
    function automatic int bits_for(input int v);
        int w;
        w = 0;
        while ((1 << w) <= v) w++;
        return w;
    endfunction

    // column height after a given number of counter levels
    function automatic int height_at(input int op_w, input int lvl);
        int h;
        h = op_w;
        for (int i = 0; i < lvl; i++) begin
            if (h > 2) h = bits_for(h);
        end
        return h;
    endfunction

    // counter levels until every column holds at most two bits
    function automatic int num_levels(input int op_w);
        int h;
        int n;
        h = op_w;
        n = 0;
        while (h > 2) begin
            h = bits_for(h);
            n++;
        end
        return n;
    endfunction

    // operand register + grouped counter stages + final adder register
    function automatic int pipe_latency(input int op_w, input int per_reg);
        return 2 + (num_levels(op_w) + per_reg - 1) / per_reg;
    endfunction

endpackage

// File: rtl/ccm_pp.sv
`timescale 1ns/1ps
module ccm_pp #(
    parameter int OP_W = 8,
    localparam int COLS = 2 * OP_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_vld,
    input  logic [OP_W-1:0]                in_x,
    input  logic [OP_W-1:0]                in_y,
    output logic                           out_vld,
    output logic [COLS-1:0][OP_W-1:0]      out_mat
);

    typedef struct packed {
        logic                      vld;
        logic [COLS-1:0][OP_W-1:0] mat;
    } pp_st_t;

    pp_st_t st_d, st_q;

    // bit (i,j) lands in column i+j; row i is unique within that column
    always_comb begin
        st_d     = '0;
        st_d.vld = in_vld;
        for (int i = 0; i < OP_W; i++) begin
            for (int j = 0; j < OP_W; j++) begin
                st_d.mat[i+j][i] = in_x[i] & in_y[j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_mat = st_q.mat;

endmodule

// File: rtl/ccm_level.sv
`timescale 1ns/1ps
module ccm_level #(
    parameter int COLS    = 16,
    parameter int ROWS_IN = 8,
    parameter bit REG     = 1'b1,
    localparam int ROWS_OUT = ccm_pkg::bits_for(ROWS_IN)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_vld,
    input  logic [COLS-1:0][ROWS_IN-1:0]      in_mat,
    output logic                              out_vld,
    output logic [COLS-1:0][ROWS_OUT-1:0]     out_mat
);

    typedef struct packed {
        logic                          vld;
        logic [COLS-1:0][ROWS_OUT-1:0] mat;
    } lvl_st_t;

    lvl_st_t                       st_d;
    logic [COLS-1:0][ROWS_OUT-1:0] cnt;

    // count ones per column, then spread count bit j into column c+j
    always_comb begin
        cnt = '0;
        for (int c = 0; c < COLS; c++) begin
            for (int r = 0; r < ROWS_IN; r++) begin
                cnt[c] = cnt[c] + ROWS_OUT'(in_mat[c][r]);
            end
        end
        st_d     = '0;
        st_d.vld = in_vld;
        for (int c = 0; c < COLS; c++) begin
            for (int j = 0; j < ROWS_OUT && j <= c; j++) begin
                st_d.mat[c][j] = cnt[c-j][j];
            end
        end
    end

    if (REG) begin : g_reg
        lvl_st_t st_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
        assign out_vld = st_q.vld;
        assign out_mat = st_q.mat;
    end else begin : g_comb
        assign out_vld = st_d.vld;
        assign out_mat = st_d.mat;
    end

endmodule

// File: rtl/ccm_final.sv
`timescale 1ns/1ps
module ccm_final #(
    parameter int COLS = 16,
    parameter int ROWS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_vld,
    input  logic [COLS-1:0][ROWS-1:0]     in_mat,
    output logic                          out_vld,
    output logic [COLS-1:0]               out_sum
);

    typedef struct packed {
        logic            vld;
        logic [COLS-1:0] sum;
    } fin_st_t;

    fin_st_t         st_d, st_q;
    logic [COLS-1:0] row_a, row_b;

    for (genvar c = 0; c < COLS; c++) begin : g_rows
        assign row_a[c] = in_mat[c][0];
        if (ROWS > 1) begin : g_two
            assign row_b[c] = in_mat[c][1];
        end else begin : g_one
            assign row_b[c] = 1'b0;
        end
    end

    always_comb begin
        st_d.vld = in_vld;
        st_d.sum = row_a + row_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_sum = st_q.sum;

endmodule

// File: rtl/colcount_mult.sv
`timescale 1ns/1ps
module colcount_mult
    import ccm_pkg::*;
#(
    parameter int OP_W        = 8,
    parameter int LVL_PER_REG = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_vld,
    input  logic [OP_W-1:0]       op_x,
    input  logic [OP_W-1:0]       op_y,
    output logic                  res_vld,
    output logic [2*OP_W-1:0]     res_prod
);

    localparam int COLS  = 2 * OP_W;
    localparam int NLVL  = num_levels(OP_W);
    localparam int FROWS = height_at(OP_W, NLVL);

    logic                      pp_vld;
    logic [COLS-1:0][OP_W-1:0] pp_mat;
    logic                      fin_vld;
    logic [COLS-1:0][FROWS-1:0] fin_mat;

    ccm_pp #(.OP_W(OP_W)) u_pp (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (op_vld),
        .in_x    (op_x),
        .in_y    (op_y),
        .out_vld (pp_vld),
        .out_mat (pp_mat)
    );

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        localparam int RI = height_at(OP_W, l);
        localparam int RO = height_at(OP_W, l + 1);
        // a stage boundary after every LVL_PER_REG levels and after the last
        localparam bit DO_REG = (((l + 1) % LVL_PER_REG) == 0) || (l == NLVL - 1);

        logic                    vld_i, vld_o;
        logic [COLS-1:0][RI-1:0] mat_i;
        logic [COLS-1:0][RO-1:0] mat_o;

        if (l == 0) begin : g_first
            assign vld_i = pp_vld;
            assign mat_i = pp_mat;
        end else begin : g_next
            assign vld_i = g_lvl[l-1].vld_o;
            assign mat_i = g_lvl[l-1].mat_o;
        end

        ccm_level #(.COLS(COLS), .ROWS_IN(RI), .REG(DO_REG)) u_lvl (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (vld_i),
            .in_mat  (mat_i),
            .out_vld (vld_o),
            .out_mat (mat_o)
        );
    end

    if (NLVL == 0) begin : g_nolvl
        assign fin_vld = pp_vld;
        assign fin_mat = pp_mat;
    end else begin : g_haslvl
        assign fin_vld = g_lvl[NLVL-1].vld_o;
        assign fin_mat = g_lvl[NLVL-1].mat_o;
    end

    ccm_final #(.COLS(COLS), .ROWS(FROWS)) u_fin (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (fin_vld),
        .in_mat  (fin_mat),
        .out_vld (res_vld),
        .out_sum (res_prod)
    );

endmodule

// File: rtl/colcount_mult_chk.sv
`timescale 1ns/1ps
module colcount_mult_chk
    import ccm_pkg::*;
#(
    parameter int OP_W        = 8,
    parameter int LVL_PER_REG = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  op_vld,
    input logic [OP_W-1:0]       op_x,
    input logic [OP_W-1:0]       op_y,
    input logic                  res_vld,
    input logic [2*OP_W-1:0]     res_prod
);

    localparam int PW  = 2 * OP_W;
    localparam int LAT = pipe_latency(OP_W, LVL_PER_REG);
    localparam logic [PW-1:0] MAXP =
        {{OP_W{1'b0}}, {OP_W{1'b1}}} * {{OP_W{1'b0}}, {OP_W{1'b1}}};

    logic [LAT-1:0] vhist;
    logic [LAT-1:0] zhist;
    logic [PW-1:0]  phist [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vhist <= '0;
            zhist <= '0;
            for (int i = 0; i < LAT; i++) phist[i] <= '0;
        end else begin
            vhist    <= {vhist[LAT-2:0], op_vld};
            zhist    <= {zhist[LAT-2:0], (op_x == '0) || (op_y == '0)};
            phist[0] <= PW'(op_x) * PW'(op_y);
            for (int i = 1; i < LAT; i++) phist[i] <= phist[i-1];
        end
    end

    AST_VLD_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld == vhist[LAT-1]); // R4

    AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> res_prod == phist[LAT-1]); // R1

    AST_PROD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> res_prod <= MAXP); // R6

    AST_ZERO_OPND: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && zhist[LAT-1]) |-> res_prod == '0); // R5

endmodule

bind colcount_mult colcount_mult_chk #(
    .OP_W        (OP_W),
    .LVL_PER_REG (LVL_PER_REG)
) u_chk (.*);

// File: tb/sim_colcount_mult.sv
`timescale 1ns/1ps
module sim_colcount_mult;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vld = 1'b0;
    logic [3:0] x4 = '0, y4 = '0;
    logic [7:0] x8 = '0, y8 = '0;
    logic       v0, v1, v2;
    logic [7:0] p0, p1;
    logic [15:0] p2;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk; // 50 MHz

    colcount_mult #(.OP_W(4), .LVL_PER_REG(1)) u0 (
        .clk(clk), .rst_n(rst_n), .op_vld(vld), .op_x(x4), .op_y(y4),
        .res_vld(v0), .res_prod(p0));
    colcount_mult #(.OP_W(4), .LVL_PER_REG(2)) u1 (
        .clk(clk), .rst_n(rst_n), .op_vld(vld), .op_x(x4), .op_y(y4),
        .res_vld(v1), .res_prod(p1));
    colcount_mult #(.OP_W(8), .LVL_PER_REG(3)) u2 (
        .clk(clk), .rst_n(rst_n), .op_vld(vld), .op_x(x8), .op_y(y8),
        .res_vld(v2), .res_prod(p2));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // latency from the level rule of R3
    function automatic int lat_of(input int w, input int k);
        int h, n, b;
        h = w;
        n = 0;
        while (h > 2) begin
            b = 0;
            while ((1 << b) <= h) b++;
            h = b;
            n++;
        end
        return 2 + (n + k - 1) / k;
    endfunction

    function automatic bit one_bit(input longint v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic int tag_of(input longint a, input longint b, input longint all1, input bit gap);
        if (a == 0 || b == 0)           return 5;
        if (a == all1 && b == all1)     return 6;
        if (one_bit(a) || one_bit(b))   return 7;
        if (gap)                        return 2;
        return 1;
    endfunction

    function automatic string tag_name(input int t);
        case (t)
            2: return "R2";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R1";
        endcase
    endfunction

    function automatic logic [7:0] sel8(input int s);
        case (s)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h01;
            3: return 8'h02;
            4: return 8'h04;
            5: return 8'h10;
            6: return 8'h80;
            default: return 8'hA5;
        endcase
    endfunction

    bit     hv [64];
    longint e4 [64];
    longint e8 [64];
    int     t4 [64];
    int     t8 [64];

    initial begin
        int     lat [3];
        int     orun [3];
        int     omax [3];
        bit     seen [3];
        int     irun, imax;
        bit     av, ev, gap;
        longint ap, ep;
        int     idx, tg;

        lat[0] = lat_of(4, 1);
        lat[1] = lat_of(4, 2);
        lat[2] = lat_of(8, 3);
        for (int d = 0; d < 3; d++) begin
            orun[d] = 0; omax[d] = 0; seen[d] = 1'b0;
        end
        irun = 0; imax = 0;
        for (int i = 0; i < 64; i++) begin
            hv[i] = 1'b0; e4[i] = 0; e8[i] = 0; t4[i] = 1; t8[i] = 1;
        end

        // R8: no valid result while reset is held
        repeat (3) @(negedge clk);
        chk(v0 == 1'b0, "R8", v0, 0);
        chk(v1 == 1'b0, "R8", v1, 0);
        chk(v2 == 1'b0, "R8", v2, 0);
        rst_n = 1'b1;

        for (int c = 0; c < 370; c++) begin
            @(negedge clk);
            // outputs now reflect pairs driven lat cycles earlier
            for (int d = 0; d < 3; d++) begin
                idx = c - lat[d];
                ev  = (idx >= 0) ? hv[idx % 64] : 1'b0;
                av  = (d == 0) ? v0 : (d == 1) ? v1 : v2;
                ap  = (d == 0) ? longint'(p0) : (d == 1) ? longint'(p1) : longint'(p2);
                chk(av == ev, "R4", av, ev);
                if (ev) begin
                    ep = (d < 2) ? e4[idx % 64] : e8[idx % 64];
                    tg = (d < 2) ? t4[idx % 64] : t8[idx % 64];
                    chk(ap == ep, tag_name(tg), ap, ep);
                end
                if (av) orun[d]++;
                else    orun[d] = 0;
                if (orun[d] > omax[d]) omax[d] = orun[d];
                if (c > 340 && av && !seen[d]) begin
                    seen[d] = 1'b1;
                    chk((c - 340) == lat[d], "R3", c - 340, lat[d]);
                end
            end

            gap = 1'b0;
            if (c < 256) begin
                vld = 1'b1;
                x4  = c[3:0];
                y4  = c[7:4];
                x8  = {c[3:0], c[7:4]};
                y8  = {c[7:4], c[3:0]};
            end else if (c < 320) begin
                gap = 1'b1;
                vld = ((c - 256) % 3) != 2;
                x8  = sel8((c - 256) % 8);
                y8  = sel8(((c - 256) / 8) % 8);
                x4  = x8[3:0];
                y4  = y8[3:0];
            end else if (c == 340) begin
                vld = 1'b1;
                x4 = 4'd3; y4 = 4'd5; x8 = 8'd200; y8 = 8'd3;
            end else begin
                // idle cycles carry junk operands
                vld = 1'b0;
                x4 = 4'(c * 37); y4 = 4'(c * 11);
                x8 = 8'(c * 37); y8 = 8'(c * 91);
            end
            hv[c % 64] = vld;
            e4[c % 64] = longint'(x4) * longint'(y4);
            e8[c % 64] = longint'(x8) * longint'(y8);
            t4[c % 64] = tag_of(x4, y4, 15, gap);
            t8[c % 64] = tag_of(x8, y8, 255, gap);
            if (vld) irun++;
            else     irun = 0;
            if (irun > imax) imax = irun;
        end

        for (int d = 0; d < 3; d++) begin
            chk(omax[d] == imax, "R2", omax[d], imax);
            chk(seen[d], "R3", seen[d], 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule